// File: doc/BRIEF.md
# Narrow-Link Analog Register Access Master

This block connects a CPU-side register bus to a narrow link that reaches 8-bit registers in an analog domain. The link has an 8-bit write lane and a 4-bit read lane. The master turns each CPU access into a sequence of short link transactions and issues them one after another. For reads, it builds the full word from the returned nibbles.

The CPU can read 8, 16 or 32 bits. It can write in three direct flavours: plain write, bit set and bit clear. Each of these covers one, two or four consecutive registers. A masked write carries a 16-bit mask and 16-bit data. It changes only the masked bits, one nibble per link transaction, so no read-modify-write is needed.

Writes can be posted or non-posted. A posted write goes into a small buffer and the CPU continues at once. A non-posted write holds the CPU until the write has finished on the link. A read waits until the buffer has drained, so a read also serves as a completion barrier.

Top module: `narrow_reg_master`

## Requirements
- R1: After reset `cpu_ack` is 0, all three link phase strobes are 0 and `cpu_rdata` is 0.
- R2: Each link transaction has three phases:
  - one cycle with `lk_cmd` high;
  - one cycle with `lk_dat` high;
  - at least one cycle with `lk_fin` high, extended by one cycle for every cycle that `lk_busy` is high during `lk_fin`.

  `lk_rd`, `lk_op`, `lk_half`, `lk_addr` and `lk_wdata` stay constant through a transaction. The next transaction of the same access starts in the cycle after the last `lk_fin`.
- R3: A read of 8, 16 or 32 bits makes 2, 4 or 8 transactions with `lk_rd`=1. Nibble k is read from address base+k/2, with `lk_half` = k mod 2 (1 selects bits 7:4). The returned nibble k is placed at `cpu_rdata[4k+3:4k]`, and the unused upper bits are 0.
- R4: A direct access uses `cpu_op` 00 for write, 01 for set and 10 for clear, and copies that value to `lk_op`. It makes one transaction per byte (1, 2 or 4), in ascending addresses from base. `lk_wdata` carries `cpu_wdata` byte k, `lk_half`=0 and `lk_rd`=0.
- R5: A masked write (`cpu_op`=11) takes its mask from `cpu_wdata[31:16]` and its data from `cpu_wdata[15:0]`. It makes 2 transactions at 8 bits and 4 at 16 bits. Transaction k has `lk_op`=11, `lk_wdata` = {mask nibble k, data nibble k}, address base+k/2 and `lk_half` = k mod 2.
- R6: A 4-bit masked write makes one transaction at the base address. `lk_half` equals `cpu_nib_hi`, and `lk_wdata` = {`cpu_wdata[19:16]`, `cpu_wdata[3:0]`}.
- R7: `cpu_size` encodes 0=4 bits, 1=8, 2=16 and 3=32. Size 0 acts as 8 bits for reads and direct writes. A masked write with size 3 acts as 16 bits.
- R8: A posted write (`cpu_we`=1, `cpu_posted`=1) is acknowledged in the same cycle as its request when the buffer has room. Its link transactions start only after that acknowledge.
- R9: The buffer holds 2 posted writes. A posted write that finds it full sees `cpu_ack` low until an entry frees.
- R10: A non-posted write or a read is acknowledged in the cycle after the `lk_fin` cycle of its last transaction. For an access of n transactions, each stretched by s busy cycles, started on an idle master with an empty buffer, `cpu_ack` goes high 1+n·(3+s) cycles after `cpu_req`.
- R11: A read, with either value of `cpu_posted`, is acknowledged only after all earlier buffered writes have finished on the link.
- R12: Buffered writes reach the link in the order they were accepted, with no interleaving of their transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until the cycle with `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_posted | input | 1 | Write completes without waiting for the link |
| cpu_op | input | 2 | 00 write, 01 set, 10 clear, 11 masked write |
| cpu_size | input | 2 | 0=4, 1=8, 2=16, 3=32 bits |
| cpu_nib_hi | input | 1 | Upper-nibble select for 4-bit masked writes |
| cpu_addr | input | AW | Base register address |
| cpu_wdata | input | 32 | Write data, or mask (31:16) and data (15:0) |
| cpu_ack | output | 1 | Access accepted/completed this cycle |
| cpu_rdata | output | 32 | Assembled read word, valid with `cpu_ack` on reads |
| lk_cmd | output | 1 | Command phase of a link transaction |
| lk_dat | output | 1 | Address/data phase |
| lk_fin | output | 1 | Completion phase |
| lk_rd | output | 1 | Transaction is a nibble read |
| lk_op | output | 2 | Link opcode |
| lk_half | output | 1 | Nibble select within the register |
| lk_addr | output | AW | Register address |
| lk_wdata | output | 8 | Write lane |
| lk_busy | input | 1 | Slave stretches the completion phase |
| lk_rdata | input | 4 | Read lane, sampled in the last completion cycle |

## Verification
The bench changes the busy stretch per scenario. It measures the exact acknowledge latency, so an extra or missing pipeline cycle shows up as an off-by-one count. It also checks that the busy stretch is honoured rather than ignored.

Reads at base 0xFE wrap the address. A design that walked the halves in the wrong order, or packed nibbles most significant first, would return a scrambled word.

For masked writes, the bench swaps the mask and data nibbles and tests the lone upper-nibble case. Lane swaps and a wrong half-select would then appear in the transaction log.

Four back-to-back posted 32-bit writes fill the buffer, so a third-entry overflow or a premature acknowledge would be caught. A read after them must wait until all 16 write transactions have been logged, which catches a read that overtakes the buffer.

// File: rtl/narrow_reg_master.sv
module narrow_reg_master #(
  parameter int AW     = 8,
  parameter int QDEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic          cpu_posted,
  input  logic [1:0]    cpu_op,
  input  logic [1:0]    cpu_size,
  input  logic          cpu_nib_hi,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic          cpu_ack,
  output logic [31:0]   cpu_rdata,
  output logic          lk_cmd,
  output logic          lk_dat,
  output logic          lk_fin,
  output logic          lk_rd,
  output logic [1:0]    lk_op,
  output logic          lk_half,
  output logic [AW-1:0] lk_addr,
  output logic [7:0]    lk_wdata,
  input  logic          lk_busy,
  input  logic [3:0]    lk_rdata
);

  localparam int QW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW = $clog2(QDEPTH + 1);
  localparam logic [1:0] OP_MASK = 2'b11;

  typedef struct packed {
    logic          rd;
    logic [1:0]    op;
    logic [2:0]    last;
    logic          hi;
    logic [AW-1:0] addr;
    logic [31:0]   data;
  } job_t;

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_DAT, S_FIN} ph_t;

  job_t          q_mem [QDEPTH];
  logic [QW-1:0] q_wp, q_rp;
  logic [CW-1:0] q_cnt;
  ph_t           ph;
  job_t          cur;
  logic          cur_blk;
  logic [2:0]    idx;
  logic          ack_q;
  logic [31:0]   rd_q;

  job_t in_job;
  logic [2:0] in_last;

  always_comb begin
    if (!cpu_we)
      case (cpu_size)
        2'd2:    in_last = 3'd3;
        2'd3:    in_last = 3'd7;
        default: in_last = 3'd1;
      endcase
    else if (cpu_op != OP_MASK)
      case (cpu_size)
        2'd2:    in_last = 3'd1;
        2'd3:    in_last = 3'd3;
        default: in_last = 3'd0;
      endcase
    else
      case (cpu_size)
        2'd0:    in_last = 3'd0;
        2'd1:    in_last = 3'd1;
        default: in_last = 3'd3;
      endcase
  end

  assign in_job.rd   = !cpu_we;
  assign in_job.op   = cpu_we ? cpu_op : 2'b00;
  assign in_job.last = in_last;
  assign in_job.hi   = cpu_we & cpu_nib_hi & (cpu_op == OP_MASK) & (cpu_size == 2'd0);
  assign in_job.addr = cpu_addr;
  assign in_job.data = cpu_wdata;

  wire q_full   = (q_cnt == CW'(QDEPTH));
  wire q_empty  = (q_cnt == '0);
  wire idle     = (ph == S_IDLE);
  wire post_req = cpu_req & cpu_we & cpu_posted;
  wire blk_req  = cpu_req & ~(cpu_we & cpu_posted);
  wire push     = post_req & ~q_full;
  wire pop      = idle & ~q_empty;
  wire blk_go   = idle & q_empty & blk_req & ~ack_q;

  assign cpu_ack   = push | ack_q;
  assign cpu_rdata = rd_q;
  assign lk_cmd    = (ph == S_CMD);
  assign lk_dat    = (ph == S_DAT);
  assign lk_fin    = (ph == S_FIN);

  function automatic logic [QW-1:0] q_next(input logic [QW-1:0] p);
    return (p == QW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [2:0] nib;
  assign nib = idx + {2'b00, cur.hi};

  always_comb begin
    lk_rd    = 1'b0;
    lk_op    = 2'b00;
    lk_half  = 1'b0;
    lk_addr  = '0;
    lk_wdata = '0;
    if (!idle) begin
      lk_rd = cur.rd;
      lk_op = cur.op;
      if (cur.rd) begin
        lk_addr = cur.addr + AW'(idx[2:1]);
        lk_half = idx[0];
      end else if (cur.op == OP_MASK) begin
        lk_addr  = cur.addr + AW'(nib[2:1]);
        lk_half  = nib[0];
        lk_wdata = {cur.data[16 + 4*idx[1:0] +: 4], cur.data[4*idx[1:0] +: 4]};
      end else begin
        lk_addr  = cur.addr + AW'(idx[1:0]);
        lk_wdata = cur.data[8*idx[1:0] +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) q_mem[q_wp] <= in_job;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_wp    <= '0;
      q_rp    <= '0;
      q_cnt   <= '0;
      ph      <= S_IDLE;
      cur     <= '0;
      cur_blk <= 1'b0;
      idx     <= '0;
      ack_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      ack_q <= 1'b0;
      if (push) q_wp <= q_next(q_wp);
      if (pop)  q_rp <= q_next(q_rp);
      q_cnt <= q_cnt + CW'(push) - CW'(pop);
      case (ph)
        S_IDLE: begin
          idx <= '0;
          if (pop) begin
            cur     <= q_mem[q_rp];
            cur_blk <= 1'b0;
            ph      <= S_CMD;
          end else if (blk_go) begin
            cur     <= in_job;
            cur_blk <= 1'b1;
            rd_q    <= '0;
            ph      <= S_CMD;
          end
        end
        S_CMD: ph <= S_DAT;
        S_DAT: ph <= S_FIN;
        default: begin
          if (!lk_busy) begin
            if (cur.rd) rd_q[4*idx +: 4] <= lk_rdata;
            if (idx == cur.last) begin
              ph      <= S_IDLE;
              ack_q   <= cur_blk;
              cur_blk <= 1'b0;
            end else begin
              idx <= idx + 1'b1;
              ph  <= S_CMD;
            end
          end
        end
      endcase
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lk_cmd && !lk_dat && !lk_fin && !cpu_ack);

  // R2
  cmd_to_dat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_cmd |=> lk_dat);

  // R2
  dat_to_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_dat |=> lk_fin);

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fin && lk_busy |=> lk_fin);

  // R2
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_cmd, lk_dat, lk_fin}));

  // R2
  fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_dat || lk_fin) |-> $stable({lk_rd, lk_op, lk_half, lk_addr, lk_wdata}));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && cpu_we && cpu_posted |-> q_cnt < CW'(QDEPTH));

  // R10
  blk_ack_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && !(cpu_we && cpu_posted) |-> $past(lk_fin) && !$past(lk_busy));

  // R11
  read_barrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && !cpu_we |-> q_empty && !lk_cmd && !lk_dat && !lk_fin);

endmodule

// File: tb/narrow_reg_master_test.sv
`timescale 1ns/1ps
module narrow_reg_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, cpu_posted = 0, cpu_nib_hi = 0;
  logic [1:0] cpu_op = 0, cpu_size = 0;
  logic [7:0] cpu_addr = 0;
  logic [31:0] cpu_wdata = 0;
  logic cpu_ack;
  logic [31:0] cpu_rdata;
  logic lk_cmd, lk_dat, lk_fin, lk_rd, lk_half;
  logic [1:0] lk_op;
  logic [7:0] lk_addr, lk_wdata, mv;
  logic lk_busy = 0;
  logic [3:0] lk_rdata;

  narrow_reg_master #(.AW(8), .QDEPTH(2)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_posted(cpu_posted), .cpu_op(cpu_op), .cpu_size(cpu_size),
    .cpu_nib_hi(cpu_nib_hi), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .lk_cmd(lk_cmd), .lk_dat(lk_dat),
    .lk_fin(lk_fin), .lk_rd(lk_rd), .lk_op(lk_op), .lk_half(lk_half),
    .lk_addr(lk_addr), .lk_wdata(lk_wdata), .lk_busy(lk_busy), .lk_rdata(lk_rdata));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, stretch = 0, bleft = 0, lg_n = 0;
  logic        lg_rd [256];
  logic [1:0]  lg_op [256];
  logic [7:0]  lg_addr [256];
  logic [7:0]  lg_wd [256];
  logic        lg_half [256];
  int          lg_cyc [256];

  function automatic logic [7:0] mval(input logic [7:0] a);
    return (a * 8'd37) ^ 8'h5A;
  endfunction

  assign mv = mval(lk_addr);
  assign lk_rdata = lk_half ? mv[7:4] : mv[3:0];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (lk_cmd) begin
      bleft = stretch;
      if (lg_n < 256) begin
        lg_rd[lg_n] = lk_rd; lg_op[lg_n] = lk_op; lg_addr[lg_n] = lk_addr;
        lg_wd[lg_n] = lk_wdata; lg_half[lg_n] = lk_half; lg_cyc[lg_n] = cyc;
        lg_n = lg_n + 1;
      end
    end
    if (lk_fin && bleft > 0) begin lk_busy = 1; bleft = bleft - 1; end
    else lk_busy = 0;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_txn(input int i, input logic rd, input logic [1:0] op, input logic [7:0] a,
                         input logic [7:0] wd, input logic h, input string tag);
    check(lg_rd[i] == rd, {tag, " rd"}, 32'(lg_rd[i]), 32'(rd));
    check(lg_addr[i] == a, {tag, " addr"}, 32'(lg_addr[i]), 32'(a));
    check(lg_half[i] == h, {tag, " half"}, 32'(lg_half[i]), 32'(h));
    if (!rd) begin
      check(lg_op[i] == op, {tag, " op"}, 32'(lg_op[i]), 32'(op));
      check(lg_wd[i] == wd, {tag, " wdata"}, 32'(lg_wd[i]), 32'(wd));
    end
  endtask

  task automatic access(input logic we, input logic posted, input logic [1:0] op, input logic [1:0] sz,
                        input logic hi, input logic [7:0] a, input logic [31:0] wd,
                        output int waitc, output logic [31:0] rdv, output int logc);
    int c0;
    cpu_we = we; cpu_posted = posted; cpu_op = op; cpu_size = sz;
    cpu_nib_hi = hi; cpu_addr = a; cpu_wdata = wd; cpu_req = 1;
    c0 = cyc;
    forever begin
      #1;
      if (cpu_ack) break;
      @(negedge clk);
    end
    waitc = cyc - c0; rdv = cpu_rdata; logc = lg_n;
    @(negedge clk);
    cpu_req = 0;
  endtask

  task automatic t_reset();
    check(cpu_ack == 0, "R1 ack", 32'(cpu_ack), 0);
    check({lk_cmd, lk_dat, lk_fin} == 3'b000, "R1 phases", 32'({lk_cmd, lk_dat, lk_fin}), 0);
    check(cpu_rdata == 0, "R1 rdata", cpu_rdata, 0);
  endtask

  task automatic t_read(input logic [1:0] sz, input logic [7:0] a, input int s, input logic posted);
    int n, base, w, lc; logic [31:0] r, exp; logic [7:0] b;
    stretch = s; base = lg_n;
    n = (sz == 2) ? 4 : (sz == 3) ? 8 : 2;
    exp = 0;
    for (int k = 0; k < n; k++) begin
      b = mval(a + 8'(k / 2));
      exp[4*k +: 4] = (k % 2) ? b[7:4] : b[3:0];
    end
    access(0, posted, 2'b00, sz, 0, a, 32'h0, w, r, lc);
    check(r == exp, "R3 read word", r, exp);
    check(lc - base == n, "R3 read count", 32'(lc - base), 32'(n));
    check(w == 1 + n * (3 + s), "R10 read latency", 32'(w), 32'(1 + n * (3 + s)));
    for (int k = 0; k < n; k++) chk_txn(base + k, 1, 0, a + 8'(k / 2), 0, 1'(k % 2), "R3 read txn");
    for (int k = 1; k < n; k++)
      check(lg_cyc[base+k] - lg_cyc[base+k-1] == 3 + s, "R2 spacing",
            32'(lg_cyc[base+k] - lg_cyc[base+k-1]), 32'(3 + s));
    stretch = 0;
  endtask

  task automatic t_direct(input logic [1:0] op, input logic [1:0] sz, input logic [7:0] a, input logic [31:0] wd);
    int n, base, w, lc; logic [31:0] r;
    base = lg_n;
    n = (sz == 2) ? 2 : (sz == 3) ? 4 : 1;
    access(1, 0, op, sz, 0, a, wd, w, r, lc);
    check(lc - base == n, "R4 byte count", 32'(lc - base), 32'(n));
    check(w == 1 + 3 * n, "R10 write latency", 32'(w), 32'(1 + 3 * n));
    for (int k = 0; k < n; k++) chk_txn(base + k, 0, op, a + 8'(k), wd[8*k +: 8], 0, "R4 direct txn");
  endtask

  task automatic t_masked(input logic [1:0] sz, input logic hi, input logic [7:0] a, input logic [31:0] wd);
    int n, base, w, lc, p; logic [31:0] r;
    base = lg_n;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    access(1, 0, 2'b11, sz, hi, a, wd, w, r, lc);
    check(lc - base == n, "R5 nibble count", 32'(lc - base), 32'(n));
    for (int k = 0; k < n; k++) begin
      p = k + ((sz == 0 && hi) ? 1 : 0);
      chk_txn(base + k, 0, 2'b11, a + 8'(p / 2), {wd[16+4*k +: 4], wd[4*k +: 4]}, 1'(p % 2),
              (sz == 0) ? "R6 narrow masked" : "R5 masked txn");
    end
  endtask

  task automatic t_posted();
    int w[4], lc[4], base, wr, lr; logic [31:0] r;
    logic [7:0] ab[4]; logic [31:0] dv[4];
    stretch = 2; base = lg_n;
    for (int j = 0; j < 4; j++) begin ab[j] = 8'(16 * j + 3); dv[j] = 32'h11223344 + 32'(j) * 32'h01010101; end
    for (int j = 0; j < 4; j++) access(1, 1, 2'b00, 2'd3, 0, ab[j], dv[j], w[j], r, lc[j]);
    check(w[0] == 0, "R8 immediate ack", 32'(w[0]), 0);
    check(lc[0] == base, "R8 link later", 32'(lc[0] - base), 0);
    check(w[1] == 0 && w[2] == 0, "R9 room for two", 32'(w[1] + w[2]), 0);
    check(w[3] > 0, "R9 full stall", 32'(w[3]), 32'd1);
    access(0, 1, 2'b00, 2'd1, 0, 8'h80, 0, wr, r, lr);
    check(lr - base == 18, "R11 barrier", 32'(lr - base), 32'd18);
    for (int j = 0; j < 4; j++)
      for (int k = 0; k < 4; k++)
        chk_txn(base + 4*j + k, 0, 2'b00, ab[j] + 8'(k), dv[j][8*k +: 8], 0, "R12 order");
    check(r == {24'h0, mval(8'h80)}, "R11 read after writes", r, {24'h0, mval(8'h80)});
    stretch = 0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read(2'd1, 8'h0A, 0, 0);
    t_read(2'd2, 8'h40, 1, 0);
    t_read(2'd3, 8'hFE, 0, 1);
    t_read(2'd0, 8'h33, 0, 0);             // R7 size 0 read acts as 8-bit
    t_direct(2'b00, 2'd1, 8'h20, 32'h000000C3);
    t_direct(2'b01, 2'd2, 8'h21, 32'h00005AA5);
    t_direct(2'b10, 2'd3, 8'h30, 32'hDEADBEEF);
    t_direct(2'b00, 2'd0, 8'h50, 32'h0000007E);   // R7 size 0 direct acts as 8-bit
    t_masked(2'd0, 1'b0, 8'h60, 32'h000A0005);
    t_masked(2'd0, 1'b1, 8'h61, 32'h000C0003);
    t_masked(2'd1, 1'b1, 8'h62, 32'h00F0009C);
    t_masked(2'd2, 1'b0, 8'h70, 32'hF0A51234);
    t_masked(2'd3, 1'b0, 8'h72, 32'h0FF0ABCD);    // R7 masked size 3 acts as 16-bit
    t_posted();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule